// File: doc/BRIEF.md
# Configurable Ternary Balance Gate

This block is a three-input ternary comparator modelled on a pair of scales. Operand `x` sits on the left pan, operand `z` sits on the right pan and operand `y` stands for the central axle. A weight-order triple ranks the three trit values from lightest to heaviest. A pan-value triple gives the trit that the gate outputs when the left pan sinks, when the scales balance, and when the right pan sinks. The gate weighs `x` against `z` and drives out the value of the pan that goes down. When the two operands weigh the same, it drives out the axle value. Operand `y` never changes the result.

Each configuration triple can come in on its own trit port. It can also be named by one character. In that case the character's offset from `@` is written as three base-3 digits, so `@` is 000, `A` is 001 and `Z` is 222. A mode input chooses between the two sources.

A triple that is not a permutation of 0, 1 and 2, a character outside `@`..`Z`, or an illegal operand code raises a fault flag and forces the output to 1. The result and the flag are registered. Both are reset synchronously.

Top module: `ternbal_gate`

## Requirements
- R1: When `x` ranks heavier than `z` in the weight order, `result_o` equals the left-pan value of the pan triple.
- R2: When `z` ranks heavier than `x`, `result_o` equals the right-pan value.
- R3: When `x` and `z` have the same rank, `result_o` equals the axle value.
- R4: Operand `y_i` has no effect on `result_o` or `fault_o`, including when it carries the illegal code 11.
- R5: Trits are encoded 00=0, 01=1 and 10=2. In a 6-bit triple, bits [5:4] hold the first entry, [3:2] the second and [1:0] the third. The pan triple is left, axle, right. The weight triple is lightest, middle, heaviest.
- R6: If either effective triple is not a permutation of 0, 1 and 2 (a repeated value, or an entry 11), `fault_o` is 1 and `result_o` is 1 (01).
- R7: When `use_letters_i` is 1, each triple is decoded from its 8-bit character. The value c-0x40, for c in 0x40..0x5A, is written as three base-3 digits with the most significant digit as the first entry. For example 'E' gives 012, 'S' gives 201 and 'U' gives 210.
- R8: In letter mode, a character below 0x40 or above 0x5A sets `fault_o` to 1 and `result_o` to 1. This holds even for a character whose offset taken modulo 27 would name a permutation.
- R9: Code 11 on `x_i` or on `z_i` sets `fault_o` to 1 and `result_o` to 1.
- R10: The outputs are registered. Inputs applied before a rising edge show at the outputs after that edge. While `rst` is high, an edge sets `result_o` to 0 and `fault_o` to 0.
- R11: In letter mode the triple ports are ignored. In triple mode the character ports are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_i | input | 2 | Left-pan operand trit |
| y_i | input | 2 | Axle operand trit (no effect on the result) |
| z_i | input | 2 | Right-pan operand trit |
| use_letters_i | input | 1 | 1 selects the character ports as the configuration source |
| pan_trits_i | input | 6 | Pan-value triple: left, axle, right |
| weight_trits_i | input | 6 | Weight-order triple: lightest to heaviest |
| pan_char_i | input | 8 | Pan-value triple named by one character |
| weight_char_i | input | 8 | Weight-order triple named by one character |
| result_o | output | 2 | Registered result trit |
| fault_o | output | 1 | Registered flag for a bad configuration or operand |

## Verification
The assertion that `y_i` has no effect assumes that the operands and the configuration have held steady for two edges, and it only looks at edges where `y_i` moved. The bench creates exactly that case by sweeping `y_i` through all four codes, 11 included, while `x_i`, `z_i` and the configuration stay fixed. The operand-fault and reset properties take nothing for granted about the inputs. The bench drives the code 11 on `x_i` and `z_i` deliberately, and only ever changes inputs on falling edges. The balance property is checked only when the configuration is legal and the operands are equal, which every sweep covers for each of the three trit values.

// File: rtl/ternbal_pkg.sv
package ternbal_pkg;
  localparam int TRIT_W    = 2;
  localparam int RADIX     = 3;
  localparam int TRIPLE_N  = 3;
  localparam int TRIPLE_W  = TRIT_W * TRIPLE_N;
  localparam int SYM_N     = RADIX * RADIX * RADIX;
  localparam int CHAR_W    = 8;
  localparam int CHAR_BASE = 64;

  typedef logic [TRIT_W-1:0] trit_t;

  localparam trit_t TRIT_0   = 2'd0;
  localparam trit_t TRIT_1   = 2'd1;
  localparam trit_t TRIT_2   = 2'd2;
  localparam trit_t TRIT_BAD = 2'd3;

  // first sits in the top bits; its meaning depends on the triple's role
  typedef struct packed {
    trit_t first;
    trit_t second;
    trit_t third;
  } triple_t;
endpackage

// File: rtl/ternbal_letter_dec.sv
module ternbal_letter_dec
  import ternbal_pkg::*;
#(
  parameter int CW   = CHAR_W,
  parameter int BASE = CHAR_BASE,
  parameter int NSYM = SYM_N
) (
  input  logic [CW-1:0] char_i,
  output triple_t       trip_o,
  output logic          range_bad_o
);
  localparam int IDX_W = $clog2(NSYM);

  logic [CW-1:0]    offset;
  logic [IDX_W-1:0] idx;

  always_comb begin
    offset      = char_i - CW'(BASE);
    range_bad_o = (char_i < CW'(BASE)) || (offset >= CW'(NSYM));
    idx         = range_bad_o ? '0 : offset[IDX_W-1:0];
    trip_o.third  = trit_t'(idx % RADIX);
    trip_o.second = trit_t'((idx / RADIX) % RADIX);
    trip_o.first  = trit_t'(idx / (RADIX * RADIX));
  end

  // R7: a character accepted as in range never decodes to the illegal code
  always_comb begin
    if (range_bad_o == 1'b0) begin
      p_decode_legal_r7: assert (trip_o.first != TRIT_BAD &&
                                 trip_o.second != TRIT_BAD &&
                                 trip_o.third != TRIT_BAD);
    end
  end
endmodule

// File: rtl/ternbal_perm_chk.sv
module ternbal_perm_chk
  import ternbal_pkg::*;
(
  input  triple_t trip_i,
  output logic    is_perm_o
);
  logic [RADIX-1:0] seen;
  trit_t            cur;

  always_comb begin
    seen = '0;
    for (int k = 0; k < TRIPLE_N; k++) begin
      cur = trip_i[(TRIPLE_N-1-k)*TRIT_W +: TRIT_W];
      case (cur)
        TRIT_0:  seen[0] = 1'b1;
        TRIT_1:  seen[1] = 1'b1;
        TRIT_2:  seen[2] = 1'b1;
        default: ;
      endcase
    end
    is_perm_o = &seen;
  end

  // R6: an accepted triple has three distinct entries
  always_comb begin
    if (is_perm_o == 1'b1) begin
      p_perm_distinct_r6: assert (trip_i.first != trip_i.second &&
                                  trip_i.first != trip_i.third &&
                                  trip_i.second != trip_i.third);
    end
  end
endmodule

// File: rtl/ternbal_weigh.sv
module ternbal_weigh
  import ternbal_pkg::*;
(
  input  trit_t   x_i,
  input  trit_t   z_i,
  input  triple_t pan_i,
  input  triple_t wt_i,
  output trit_t   res_o
);
  function automatic logic [1:0] rank_of(input triple_t w, input trit_t v);
    if (w.first == v)       return 2'd0;
    else if (w.second == v) return 2'd1;
    else                    return 2'd2;
  endfunction

  logic [1:0] rank_x, rank_z;

  always_comb begin
    rank_x = rank_of(wt_i, x_i);
    rank_z = rank_of(wt_i, z_i);
    if (rank_x > rank_z)      res_o = pan_i.first;
    else if (rank_z > rank_x) res_o = pan_i.third;
    else                      res_o = pan_i.second;
  end
endmodule

// File: rtl/ternbal_gate.sv
module ternbal_gate
  import ternbal_pkg::*;
#(
  parameter int CW   = CHAR_W,
  parameter int BASE = CHAR_BASE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TRIT_W-1:0]   x_i,
  input  logic [TRIT_W-1:0]   y_i,
  input  logic [TRIT_W-1:0]   z_i,
  input  logic                use_letters_i,
  input  logic [TRIPLE_W-1:0] pan_trits_i,
  input  logic [TRIPLE_W-1:0] weight_trits_i,
  input  logic [CW-1:0]       pan_char_i,
  input  logic [CW-1:0]       weight_char_i,
  output logic [TRIT_W-1:0]   result_o,
  output logic                fault_o
);
  localparam int CFG_N = 2;  // slot 0: pan values, slot 1: weight order

  logic [CW-1:0]    char_in  [CFG_N];
  triple_t          trip_in  [CFG_N];
  triple_t          let_trip [CFG_N];
  triple_t          eff_trip [CFG_N];
  logic [CFG_N-1:0] let_bad;
  logic [CFG_N-1:0] perm_ok;

  assign char_in[0] = pan_char_i;
  assign char_in[1] = weight_char_i;
  assign trip_in[0] = pan_trits_i;
  assign trip_in[1] = weight_trits_i;

  for (genvar s = 0; s < CFG_N; s++) begin : g_slot
    ternbal_letter_dec #(
      .CW   (CW),
      .BASE (BASE),
      .NSYM (SYM_N)
    ) u_dec (
      .char_i      (char_in[s]),
      .trip_o      (let_trip[s]),
      .range_bad_o (let_bad[s])
    );

    assign eff_trip[s] = use_letters_i ? let_trip[s] : trip_in[s];

    ternbal_perm_chk u_perm (
      .trip_i    (eff_trip[s]),
      .is_perm_o (perm_ok[s])
    );
  end

  trit_t raw_res;
  trit_t axle_val;
  logic  cfg_bad, operand_bad, next_fault;

  ternbal_weigh u_weigh (
    .x_i   (x_i),
    .z_i   (z_i),
    .pan_i (eff_trip[0]),
    .wt_i  (eff_trip[1]),
    .res_o (raw_res)
  );

  assign axle_val    = eff_trip[0].second;
  assign cfg_bad     = (use_letters_i && (|let_bad)) || !(&perm_ok);
  assign operand_bad = (x_i == TRIT_BAD) || (z_i == TRIT_BAD);
  assign next_fault  = cfg_bad || operand_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= TRIT_0;
      fault_o  <= 1'b0;
    end else begin
      result_o <= next_fault ? TRIT_1 : raw_res;
      fault_o  <= next_fault;
    end
  end

  // R10: the first edge after reset shows the cleared outputs
  p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (result_o == TRIT_0 && !fault_o));

  // R6: a flagged cycle always carries the default value
  p_fault_default_r6: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> result_o == TRIT_1);

  // R5: the output never carries the illegal code
  p_result_legal_r5: assert property (@(posedge clk) disable iff (rst)
    result_o != TRIT_BAD);

  // R9: an illegal operand is flagged on the next edge
  p_bad_operand_r9: assert property (@(posedge clk) disable iff (rst)
    (x_i == TRIT_BAD || z_i == TRIT_BAD) |=> (fault_o && result_o == TRIT_1));

  // R3: equal operands under a legal setup give the axle value
  p_balance_axle_r3: assert property (@(posedge clk) disable iff (rst)
    (!next_fault && x_i == z_i) |=> result_o == $past(axle_val));

  // R4: a change on y alone leaves the outputs unchanged
  p_y_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $changed(y_i) && $stable(x_i) && $stable(z_i) &&
     $stable(use_letters_i) && $stable(pan_trits_i) && $stable(weight_trits_i) &&
     $stable(pan_char_i) && $stable(weight_char_i))
    |=> ($stable(result_o) && $stable(fault_o)));
endmodule

// File: tb/ternbal_gate_tb.sv
`timescale 1ns/1ps
module ternbal_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] x_i = '0, y_i = '0, z_i = '0;
  logic       use_letters_i = 1'b0;
  logic [5:0] pan_trits_i = '0, weight_trits_i = '0;
  logic [7:0] pan_char_i = '0, weight_char_i = '0;
  logic [1:0] result_o;
  logic       fault_o;

  always #10 clk = ~clk;  // 50 MHz

  ternbal_gate dut_i (
    .clk(clk), .rst(rst), .x_i(x_i), .y_i(y_i), .z_i(z_i),
    .use_letters_i(use_letters_i), .pan_trits_i(pan_trits_i),
    .weight_trits_i(weight_trits_i), .pan_char_i(pan_char_i),
    .weight_char_i(weight_char_i), .result_o(result_o), .fault_o(fault_o)
  );

  typedef struct {
    logic [1:0] res;
    logic       flt;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   summary_done = 0;

  function automatic logic [5:0] tri3(input int a, input int b, input int c);
    return {a[1:0], b[1:0], c[1:0]};
  endfunction

  function automatic bit char_ok(input logic [7:0] c);
    return (c >= 8'h40) && (c <= 8'h5A);
  endfunction

  function automatic logic [5:0] char_trip(input logic [7:0] c);
    int v;
    if (!char_ok(c)) return 6'd0;
    v = int'(c) - 64;
    return tri3(v / 9, (v / 3) % 3, v % 3);
  endfunction

  function automatic bit is_perm(input logic [5:0] t);
    logic [1:0] a, b, c;
    a = t[5:4]; b = t[3:2]; c = t[1:0];
    return (a != 2'd3) && (b != 2'd3) && (c != 2'd3) && (a != b) && (a != c) && (b != c);
  endfunction

  function automatic int rank_of(input logic [5:0] w, input logic [1:0] v);
    for (int k = 0; k < 3; k++)
      if (w[5-2*k -: 2] == v) return k;
    return -1;
  endfunction

  task automatic drive(input logic [1:0] x, input logic [1:0] y, input logic [1:0] z,
                       input bit ul, input logic [5:0] pt, input logic [5:0] wt,
                       input logic [7:0] pc, input logic [7:0] wc, input string req);
    exp_t e;
    logic [5:0] pan, wgt;
    bit bad;
    int rx, rz;
    pan = ul ? char_trip(pc) : pt;
    wgt = ul ? char_trip(wc) : wt;
    bad = (ul && (!char_ok(pc) || !char_ok(wc))) || !is_perm(pan) || !is_perm(wgt) ||
          (x == 2'd3) || (z == 2'd3);
    e.req = req;
    if (bad) begin
      e.res = 2'd1; e.flt = 1'b1;
    end else begin
      rx = rank_of(wgt, x); rz = rank_of(wgt, z);
      e.flt = 1'b0;
      if (rx > rz)      e.res = pan[5:4];
      else if (rz > rx) e.res = pan[1:0];
      else              e.res = pan[3:2];
    end
    @(negedge clk);
    x_i = x; y_i = y; z_i = z; use_letters_i = ul;
    pan_trits_i = pt; weight_trits_i = wt; pan_char_i = pc; weight_char_i = wc;
    exp_q.push_back(e);
  endtask

  // every x and z in 0..2 against every y code, 11 included (R4)
  task automatic sweep(input bit ul, input logic [5:0] pt, input logic [5:0] wt,
                       input logic [7:0] pc, input logic [7:0] wc, input string req);
    for (int x = 0; x < 3; x++)
      for (int z = 0; z < 3; z++)
        for (int y = 0; y < 4; y++)
          drive(x[1:0], y[1:0], z[1:0], ul, pt, wt, pc, wc, req);
  endtask

  task automatic print_summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // monitor: each output change is compared one edge after its inputs were applied (R10)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (result_o !== e.res || fault_o !== e.flt) begin
          n_bad++;
          $display("FAIL %s: result=%0d fault=%0d expected result=%0d fault=%0d",
                   e.req, result_o, fault_o, e.res, e.flt);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    print_summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (result_o !== 2'd0 || fault_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: result=%0d fault=%0d expected result=0 fault=0", result_o, fault_o);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 R4 R10: ascending weights; the character ports carry junk (R11)
    sweep(1'b0, tri3(0,1,2), tri3(0,1,2), 8'h21, 8'h7E, "R1 R2 R3 R4 R10 R11");
    // R5: field positions with a scrambled setup (pan 201, weights 210)
    sweep(1'b0, tri3(2,0,1), tri3(2,1,0), 8'h00, 8'hFF, "R5 R1 R2 R3");
    // R7 R11: 'S' and 'U' name the same setup; the triple ports carry illegal junk
    sweep(1'b1, 6'h3F, 6'h00, 8'h53, 8'h55, "R7 R11");
    // R7: 'E' for both triples and 'K'/'G' (102 / 021)
    sweep(1'b1, 6'h00, 6'h00, 8'h45, 8'h45, "R7");
    sweep(1'b1, 6'h00, 6'h00, 8'h4B, 8'h47, "R7");

    // R6: repeated entry, illegal entry, all-zero weight list
    drive(2'd0, 2'd0, 2'd1, 1'b0, tri3(0,0,1), tri3(0,1,2), 8'h00, 8'h00, "R6 repeat");
    drive(2'd2, 2'd0, 2'd0, 1'b0, tri3(3,1,2), tri3(0,1,2), 8'h00, 8'h00, "R6 illegal");
    drive(2'd1, 2'd0, 2'd2, 1'b0, tri3(0,1,2), tri3(0,0,0), 8'h00, 8'h00, "R6 weights");
    drive(2'd1, 2'd0, 2'd1, 1'b0, tri3(1,2,0), tri3(2,0,1), 8'h00, 8'h00, "R3 R5 legal");
    // R6 via letters: '@' is 000 and 'Z' is 222
    drive(2'd0, 2'd0, 2'd2, 1'b1, 6'h00, 6'h00, 8'h40, 8'h45, "R6 at-sign");
    drive(2'd0, 2'd0, 2'd2, 1'b1, 6'h00, 6'h00, 8'h45, 8'h5A, "R6 Z");

    // R8: out of range, including 0x60 and 0x38 whose offset modulo 27 names 'E'
    drive(2'd0, 2'd0, 2'd2, 1'b1, tri3(0,1,2), tri3(0,1,2), 8'h60, 8'h45, "R8 above");
    drive(2'd0, 2'd0, 2'd2, 1'b1, tri3(0,1,2), tri3(0,1,2), 8'h45, 8'h38, "R8 below");
    drive(2'd2, 2'd0, 2'd0, 1'b1, tri3(0,1,2), tri3(0,1,2), 8'h3F, 8'h45, "R8 3F");
    drive(2'd2, 2'd0, 2'd0, 1'b1, tri3(0,1,2), tri3(0,1,2), 8'h45, 8'h5B, "R8 5B");
    drive(2'd2, 2'd0, 2'd0, 1'b1, tri3(0,1,2), tri3(0,1,2), 8'h45, 8'h45, "R8 recover");

    // R9: illegal operand codes
    drive(2'd3, 2'd0, 2'd1, 1'b0, tri3(0,1,2), tri3(0,1,2), 8'h00, 8'h00, "R9 x");
    drive(2'd1, 2'd0, 2'd3, 1'b0, tri3(0,1,2), tri3(0,1,2), 8'h00, 8'h00, "R9 z");
    drive(2'd3, 2'd2, 2'd3, 1'b0, tri3(0,1,2), tri3(0,1,2), 8'h00, 8'h00, "R9 both");
    drive(2'd1, 2'd3, 2'd1, 1'b0, tri3(0,1,2), tri3(0,1,2), 8'h00, 8'h00, "R4 y illegal");

    repeat (4) @(negedge clk);
    print_summary();
    $finish;
  end
endmodule